// File: doc/BRIEF.md
# ADC conversion sequencer controller

This block is the digital controller that sits in front of a multi-channel analog-to-digital converter. It holds thirty-two conversion slots. Each slot is a 16-bit word that selects the input channel, gain code, single-ended or differential input, result alignment, an optional longer acquisition phase, and an alternate place to store the result. A bounds register names a first and a last slot. One pulse on `start` runs every slot from the first to the last, including the last, and wraps past slot 31 to slot 0 when the first slot is numbered above the last.

Software reaches the slots through a single data port with a 5-bit index. When `cfg_mode` is high, each accepted write stores one slot and moves the index forward by one, so a burst of writes fills consecutive slots. When `cfg_mode` is low, the read side of the port returns the stored conversion result at the index. The converter itself sits behind two valid/ready channels. The request channel carries the slot's analog controls. The result channel returns one data word for each request.

Back-pressure rules: once `adc_req_valid` is high, it stays high with its control fields unchanged until `adc_req_ready` is seen high. `adc_res_ready` is high only while a result is awaited, and a result is taken on the edge where `adc_res_valid` and `adc_res_ready` are both high. Bounds and slot writes are ignored while a sequence runs and in the cycle in which `start` is raised.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `adc_req_valid` and `adc_res_ready` are 0, the bounds readback is 0, the data-port index is 0, and every slot and every stored result reads 0.
- R2: The bounds register reads back as {3'b000, first[4:0], 3'b000, last[4:0]}, with the first slot in bits 12:8 and the last slot in bits 4:0. The other bits always read 0. A bounds write is ignored while `busy` is 1 or while `start` is 1.
- R3: With `cfg_mode`=1, a write to the data port stores the word into the slot at the index, with bit 15 forced to 0. The index then increments and wraps from 31 to 0. `idx_wr_en` loads the index directly.
- R4: A data-port write made while `busy` is 1, or in the cycle in which `start` is 1, changes neither the slots nor the index.
- R5: `dp_rd_data` shows the slot word at the index when `cfg_mode`=1, and the stored result at the index when `cfg_mode`=0.
- R6: A sequence issues one request per slot, from the first slot through the last slot in ascending order. Each request carries that slot's fields: channel in bits 4:0, differential in bit 5, alignment in bit 6, gain in bits 14:13.
- R7: When the first slot is numbered above the last, the sequence runs from the first slot up to 31, then from 0 up to the last slot.
- R8: A result is written to the slot's own number when `loc_ovr`=0, and to the slot's alternate location (bits 12:8) when `loc_ovr`=1. `loc_ovr` is sampled at the moment the result is accepted.
- R9: A request is raised in the cycle after start is accepted, or in the cycle after the previous result is accepted. When the slot's bit 7 is 1, the request comes exactly ACQ_CYCLES cycles later instead.
- R10: `adc_req_valid` holds with stable fields until it is accepted. After acceptance, `adc_res_ready` is 1 until a result arrives, and it is never high while a request is pending.
- R11: In the cycle after the last slot's result is accepted, `busy` is still 1. On the next edge `busy` falls and `done` is high for exactly that one cycle.
- R12: `start` is accepted only when `busy` is 0. A `start` raised during a sequence neither alters the sequence nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence when idle |
| loc_ovr | input | 1 | Store results at each slot's alternate location |
| cfg_mode | input | 1 | Data port mode: 1 = slot words, 0 = results |
| bnd_wr_en | input | 1 | Bounds register write strobe |
| bnd_wr_data | input | 16 | Bounds write value |
| bnd_rd_data | output | 16 | Bounds readback |
| idx_wr_en | input | 1 | Load the data-port index |
| idx_wr_data | input | 5 | New index value |
| dp_wr_en | input | 1 | Data-port write strobe |
| dp_wr_data | input | 16 | Slot word to store |
| dp_rd_data | output | 16 | Slot word or result at the index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| adc_req_valid | output | 1 | Conversion request valid |
| adc_req_ready | input | 1 | Converter accepts the request |
| adc_chan | output | 5 | Requested channel |
| adc_gain | output | 2 | Requested gain code |
| adc_diff | output | 1 | Differential input select |
| adc_align | output | 1 | Result alignment select |
| adc_res_valid | input | 1 | Conversion result valid |
| adc_res_ready | output | 1 | Controller awaits a result |
| adc_res_data | input | DATA_W | Conversion result |

## Verification
Two things can fall in the same cycle: a software write to the slots or to the bounds, and the start of a sequence. A write may also be attempted while a sequence is already running. The bench raises `start` together with a data-port write and a bounds write. It then confirms that the index has not moved, that the slot and the bounds read back unchanged, and that the sequence runs over the old bounds. It also fires a second `start`, a bounds write and a slot write while a request is pending. It then checks the readbacks and that no second sequence follows `done`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SLOT_W  = 5;
  localparam int N_SLOTS = 1 << SLOT_W;
  localparam int WORD_W  = 16;

  typedef struct packed {
    logic              rsvd;
    logic [1:0]        gain;
    logic [SLOT_W-1:0] alt_loc;
    logic              acq_ext;
    logic              align;
    logic              diff;
    logic [SLOT_W-1:0] chan;
  } slot_cfg_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ACQ,
    SQ_REQ,
    SQ_WAIT,
    SQ_FIN
  } sq_state_t;
endpackage

// File: rtl/adc_seq_cfg_bank.sv
module adc_seq_cfg_bank
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              bnd_wr_en,
  input  logic [WORD_W-1:0] bnd_wr_data,
  input  logic              cfg_mode,
  input  logic              dp_wr_en,
  input  logic [WORD_W-1:0] dp_wr_data,
  input  logic              idx_wr_en,
  input  logic [SLOT_W-1:0] idx_wr_data,
  input  logic [SLOT_W-1:0] look_slot,
  output logic [SLOT_W-1:0] first_slot,
  output logic [SLOT_W-1:0] last_slot,
  output logic [WORD_W-1:0] bnd_rd_data,
  output logic [SLOT_W-1:0] cur_idx,
  output logic [WORD_W-1:0] idx_word,
  output logic [1:0]        look_gain,
  output logic [SLOT_W-1:0] look_alt,
  output logic              look_acq,
  output logic              look_align,
  output logic              look_diff,
  output logic [SLOT_W-1:0] look_chan
);
  localparam int GAP_W = 8 - SLOT_W;

  slot_cfg_t         slots_q [N_SLOTS];
  slot_cfg_t         wr_cfg;
  slot_cfg_t         look_cfg;
  logic [SLOT_W-1:0] first_q, last_q, idx_q;
  logic              slot_we;
  logic              unused_rsvd;

  assign slot_we = cfg_mode && dp_wr_en && !lock;

  always_comb begin
    wr_cfg      = slot_cfg_t'(dp_wr_data);
    wr_cfg.rsvd = 1'b0;
  end

  assign unused_rsvd = ^{dp_wr_data[WORD_W-1], bnd_wr_data[15:8+SLOT_W],
                         bnd_wr_data[7:SLOT_W], look_cfg.rsvd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) slots_q[i] <= '0;
    end else if (slot_we) begin
      slots_q[idx_q] <= wr_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr_en) begin
      idx_q <= idx_wr_data;
    end else if (slot_we) begin
      idx_q <= idx_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (bnd_wr_en && !lock) begin
      first_q <= bnd_wr_data[8 +: SLOT_W];
      last_q  <= bnd_wr_data[0 +: SLOT_W];
    end
  end

  assign first_slot  = first_q;
  assign last_slot   = last_q;
  assign bnd_rd_data = {{GAP_W{1'b0}}, first_q, {GAP_W{1'b0}}, last_q};
  assign cur_idx     = idx_q;
  assign idx_word    = WORD_W'(slots_q[idx_q]);

  assign look_cfg    = slots_q[look_slot];
  assign look_gain   = look_cfg.gain;
  assign look_alt    = look_cfg.alt_loc;
  assign look_acq    = look_cfg.acq_ext;
  assign look_align  = look_cfg.align;
  assign look_diff   = look_cfg.diff;
  assign look_chan   = look_cfg.chan;
endmodule

// File: rtl/adc_seq_result_store.sv
module adc_seq_result_store
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [N_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] first_slot,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic              look_acq,
  input  logic [SLOT_W-1:0] look_alt,
  input  logic              loc_ovr,
  input  logic              adc_req_ready,
  input  logic              adc_res_valid,
  input  logic [DATA_W-1:0] adc_res_data,
  output logic [SLOT_W-1:0] look_slot,
  output logic              busy,
  output logic              done,
  output logic              adc_req_valid,
  output logic              adc_res_ready,
  output logic              res_we,
  output logic [SLOT_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_data
);
  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;

  sq_state_t         st_q;
  logic [SLOT_W-1:0] slot_q, alt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              res_fire;

  assign res_fire = (st_q == SQ_WAIT) && adc_res_valid;

  always_comb begin
    case (st_q)
      SQ_IDLE: look_slot = first_slot;
      SQ_WAIT: look_slot = slot_q + SLOT_W'(1);
      default: look_slot = slot_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      slot_q <= '0;
      alt_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: if (start) begin
          slot_q <= first_slot;
          st_q   <= look_acq ? SQ_ACQ : SQ_REQ;
          cnt_q  <= CNT_W'(ACQ_CYCLES - 1);
        end
        SQ_ACQ: begin
          if (cnt_q == '0) st_q <= SQ_REQ;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        SQ_REQ: if (adc_req_ready) begin
          alt_q <= look_alt;
          st_q  <= SQ_WAIT;
        end
        SQ_WAIT: if (adc_res_valid) begin
          if (slot_q == last_slot) begin
            st_q <= SQ_FIN;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
            st_q   <= look_acq ? SQ_ACQ : SQ_REQ;
            cnt_q  <= CNT_W'(ACQ_CYCLES - 1);
          end
        end
        SQ_FIN: begin
          st_q   <= SQ_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != SQ_IDLE);
  assign done          = done_q;
  assign adc_req_valid = (st_q == SQ_REQ);
  assign adc_res_ready = (st_q == SQ_WAIT);
  assign res_we        = res_fire;
  assign res_addr      = loc_ovr ? alt_q : slot_q;
  assign res_data      = adc_res_data;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ACQ_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              loc_ovr,
  input  logic              cfg_mode,
  input  logic              bnd_wr_en,
  input  logic [15:0]       bnd_wr_data,
  output logic [15:0]       bnd_rd_data,
  input  logic              idx_wr_en,
  input  logic [4:0]        idx_wr_data,
  input  logic              dp_wr_en,
  input  logic [15:0]       dp_wr_data,
  output logic [15:0]       dp_rd_data,
  output logic              busy,
  output logic              done,
  output logic              adc_req_valid,
  input  logic              adc_req_ready,
  output logic [4:0]        adc_chan,
  output logic [1:0]        adc_gain,
  output logic              adc_diff,
  output logic              adc_align,
  input  logic              adc_res_valid,
  output logic              adc_res_ready,
  input  logic [DATA_W-1:0] adc_res_data
);
  logic [SLOT_W-1:0] first_slot, last_slot, cur_idx, look_slot, look_alt;
  logic [SLOT_W-1:0] res_addr;
  logic [WORD_W-1:0] idx_word;
  logic [DATA_W-1:0] res_data, res_rd;
  logic              look_acq, res_we, lock;

  assign lock = busy || start;

  adc_seq_cfg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock       (lock),
    .bnd_wr_en  (bnd_wr_en),
    .bnd_wr_data(bnd_wr_data),
    .cfg_mode   (cfg_mode),
    .dp_wr_en   (dp_wr_en),
    .dp_wr_data (dp_wr_data),
    .idx_wr_en  (idx_wr_en),
    .idx_wr_data(idx_wr_data),
    .look_slot  (look_slot),
    .first_slot (first_slot),
    .last_slot  (last_slot),
    .bnd_rd_data(bnd_rd_data),
    .cur_idx    (cur_idx),
    .idx_word   (idx_word),
    .look_gain  (adc_gain),
    .look_alt   (look_alt),
    .look_acq   (look_acq),
    .look_align (adc_align),
    .look_diff  (adc_diff),
    .look_chan  (adc_chan)
  );

  adc_seq_engine #(.ACQ_CYCLES(ACQ_CYCLES), .DATA_W(DATA_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .first_slot   (first_slot),
    .last_slot    (last_slot),
    .look_acq     (look_acq),
    .look_alt     (look_alt),
    .loc_ovr      (loc_ovr),
    .adc_req_ready(adc_req_ready),
    .adc_res_valid(adc_res_valid),
    .adc_res_data (adc_res_data),
    .look_slot    (look_slot),
    .busy         (busy),
    .done         (done),
    .adc_req_valid(adc_req_valid),
    .adc_res_ready(adc_res_ready),
    .res_we       (res_we),
    .res_addr     (res_addr),
    .res_data     (res_data)
  );

  adc_seq_result_store #(.DATA_W(DATA_W)) u_results (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (res_we),
    .wr_addr(res_addr),
    .wr_data(res_data),
    .rd_addr(cur_idx),
    .rd_data(res_rd)
  );

  assign dp_rd_data = cfg_mode ? idx_word : WORD_W'(res_rd);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        bnd_wr_en,
  input logic [15:0] bnd_rd_data,
  input logic        adc_req_valid,
  input logic        adc_req_ready,
  input logic        adc_res_ready,
  input logic [4:0]  adc_chan,
  input logic [1:0]  adc_gain,
  input logic        adc_diff,
  input logic        adc_align
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_valid && !adc_req_ready |=> adc_req_valid && $stable(adc_chan) &&
      $stable(adc_gain) && $stable(adc_diff) && $stable(adc_align));

  // R10
  res_ready_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_res_ready |-> busy && !adc_req_valid);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  bnd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bnd_wr_en |=> $stable(bnd_rd_data));

  // R12
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .bnd_wr_en    (bnd_wr_en),
  .bnd_rd_data  (bnd_rd_data),
  .adc_req_valid(adc_req_valid),
  .adc_req_ready(adc_req_ready),
  .adc_res_ready(adc_res_ready),
  .adc_chan     (adc_chan),
  .adc_gain     (adc_gain),
  .adc_diff     (adc_diff),
  .adc_align    (adc_align)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ACQ        = 4;

  logic        clk = 1'b0;
  logic        rst_n, start, loc_ovr, cfg_mode;
  logic        bnd_wr_en, idx_wr_en, dp_wr_en;
  logic [15:0] bnd_wr_data, dp_wr_data, bnd_rd_data, dp_rd_data;
  logic [4:0]  idx_wr_data;
  logic        busy, done, adc_req_valid, adc_req_ready;
  logic [4:0]  adc_chan;
  logic [1:0]  adc_gain;
  logic        adc_diff, adc_align, adc_res_valid, adc_res_ready;
  logic [15:0] adc_res_data;

  int          n_chk = 0;
  int          n_err = 0;
  int          ord   = 0;
  logic [15:0] cfg_m [32];
  logic [15:0] res_m [32];
  logic [4:0]  idx_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_seq_ctrl #(.DATA_W(16), .ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .loc_ovr(loc_ovr), .cfg_mode(cfg_mode),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data), .bnd_rd_data(bnd_rd_data),
    .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
    .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data), .dp_rd_data(dp_rd_data),
    .busy(busy), .done(done),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready),
    .adc_chan(adc_chan), .adc_gain(adc_gain), .adc_diff(adc_diff), .adc_align(adc_align),
    .adc_res_valid(adc_res_valid), .adc_res_ready(adc_res_ready), .adc_res_data(adc_res_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    logic [4:0] ii;
    ii = 5'(i);
    return {1'b1, 2'(i % 4), 5'(31 - i), (i % 5 == 0), ii[0], ii[1], ii ^ 5'h0A};
  endfunction

  task automatic set_idx(input logic [4:0] i);
    idx_wr_en = 1'b1; idx_wr_data = i;
    @(negedge clk);
    idx_wr_en = 1'b0;
    idx_m = i;
  endtask

  task automatic wr_slot(input logic [15:0] w);
    dp_wr_en = 1'b1; dp_wr_data = w;
    @(negedge clk);
    dp_wr_en = 1'b0;
  endtask

  task automatic read_results(input string tag);
    cfg_mode = 1'b0;
    for (int i = 0; i < 32; i++) begin
      set_idx(5'(i));
      chk({"R5/R8 result ", tag}, dp_rd_data, res_m[i]);
    end
    cfg_mode = 1'b1;
  endtask

  task automatic run_seq(input int s, input int e, input logic ovr,
                         input bit intrude, input bit collide);
    logic [15:0] exp_bnd;
    logic [4:0]  slot, dest;
    logic [15:0] cm, val;
    int          n, exp_n;
    bit          first;
    exp_bnd = {3'b000, 5'(s), 3'b000, 5'(e)};
    bnd_wr_en = 1'b1; bnd_wr_data = {3'b111, 5'(s), 3'b111, 5'(e)};
    @(negedge clk);
    bnd_wr_en = 1'b0;
    chk("R2 bounds readback", bnd_rd_data, exp_bnd);
    loc_ovr = ovr;
    start = 1'b1;
    if (collide) begin
      dp_wr_en = 1'b1; dp_wr_data = 16'h3C3C;
      bnd_wr_en = 1'b1; bnd_wr_data = 16'h0101;
    end
    @(negedge clk);
    start = 1'b0; dp_wr_en = 1'b0; bnd_wr_en = 1'b0;
    if (collide) begin
      chk("R4 slot unchanged by write with start", dp_rd_data, cfg_m[idx_m]);
      chk("R2 bounds unchanged by write with start", bnd_rd_data, exp_bnd);
    end
    slot = 5'(s);
    first = 1'b1;
    forever begin
      cm = cfg_m[slot];
      n = 1;
      while (!adc_req_valid && n < 64) begin
        @(negedge clk);
        n++;
      end
      exp_n = cm[7] ? 1 + ACQ : 1;
      chk("R9 request latency", n, exp_n);
      chk("R6/R7 request fields", {adc_gain, adc_align, adc_diff, adc_chan},
          {cm[14:13], cm[6], cm[5], cm[4:0]});
      if (intrude && first) begin
        start = 1'b1;
        bnd_wr_en = 1'b1; bnd_wr_data = 16'h1F1F;
        dp_wr_en = 1'b1; dp_wr_data = 16'h5A5A;
        @(negedge clk);
        start = 1'b0; bnd_wr_en = 1'b0; dp_wr_en = 1'b0;
        chk("R2 bounds locked while busy", bnd_rd_data, exp_bnd);
        chk("R4 slot and index locked while busy", dp_rd_data, cfg_m[idx_m]);
      end
      first = 1'b0;
      for (int k = 0; k < ord % 3; k++) begin
        @(negedge clk);
        chk("R10 request held", {adc_req_valid, adc_chan}, {1'b1, cm[4:0]});
      end
      adc_req_ready = 1'b1;
      @(negedge clk);
      adc_req_ready = 1'b0;
      chk("R10 awaiting result", {adc_req_valid, adc_res_ready}, 2'b01);
      for (int k = 0; k < ord % 2; k++) @(negedge clk);
      val = {cm[4:0], cm[14:13], cm[5], cm[6], 7'(ord)};
      adc_res_valid = 1'b1; adc_res_data = val;
      @(negedge clk);
      adc_res_valid = 1'b0;
      dest = ovr ? cm[12:8] : slot;
      res_m[dest] = val;
      ord++;
      if (slot == 5'(e)) begin
        chk("R11 busy held after last result", {busy, done}, 2'b10);
        @(negedge clk);
        chk("R11 busy falls with done", {busy, done}, 2'b01);
        @(negedge clk);
        chk("R12 no further sequence, done one cycle", {busy, done, adc_req_valid}, 3'b000);
        break;
      end
      slot = slot + 5'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; loc_ovr = 1'b0; cfg_mode = 1'b1;
    bnd_wr_en = 1'b0; bnd_wr_data = '0; idx_wr_en = 1'b0; idx_wr_data = '0;
    dp_wr_en = 1'b0; dp_wr_data = '0; adc_req_ready = 1'b0;
    adc_res_valid = 1'b0; adc_res_data = '0;
    for (int i = 0; i < 32; i++) begin cfg_m[i] = '0; res_m[i] = '0; end
    idx_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 status after reset", {busy, done, adc_req_valid, adc_res_ready}, 4'b0000);
    chk("R1 bounds after reset", bnd_rd_data, 16'h0000);
    chk("R1 index after reset", dp_rd_data, 16'h0000);
    for (int i = 0; i < 32; i++) begin
      set_idx(5'(i));
      chk("R1 slot after reset", dp_rd_data, 16'h0000);
    end
    read_results("after reset R1");

    // R3: burst fill with auto-increment and wrap
    set_idx(5'd0);
    for (int i = 0; i < 32; i++) begin
      wr_slot(pat(i));
      cfg_m[i] = pat(i) & 16'h7FFF;
    end
    idx_m = 5'd0;
    chk("R3 index wrapped to slot 0", dp_rd_data, cfg_m[0]);
    for (int i = 0; i < 32; i++) begin
      set_idx(5'(i));
      chk("R3 slot readback", dp_rd_data, cfg_m[i]);
    end
    set_idx(5'd31);
    chk("R5 mode 1 shows slot word", dp_rd_data, cfg_m[31]);

    run_seq(3, 7, 1'b0, 1'b0, 1'b0);
    read_results("R6 ascending run");
    run_seq(30, 2, 1'b1, 1'b0, 1'b0);
    read_results("R7 wrapped run with override");
    run_seq(5, 5, 1'b1, 1'b1, 1'b0);
    read_results("R12 single slot with intrusion");
    set_idx(5'd9);
    run_seq(12, 14, 1'b0, 1'b0, 1'b1);
    read_results("R4 start collision");
    run_seq(0, 31, 1'b0, 1'b0, 1'b0);
    read_results("R6 full run");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule